// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Collector

This block gathers twenty-four interrupt request lines into one cascade request for a host processor. The lines form three banks of eight, and each bank has a pending-status byte and an enable byte on a small byte-wide register bus. Every input except one is edge-captured. A rising edge on an enabled input latches a pending bit, and that bit stays set until software reads the bank's status byte. The read clears the bit, so no separate acknowledge is needed.

One input is level-sensitive. Its status bit shows the live input level, qualified by its enable bit, and a read never clears it. Edges that arrive while an input is disabled are dropped for good. The cascade output is meant for a host pin that detects rising edges. For that reason the output is forced low for one cycle after every status read, so that a request which is still pending, or has newly arrived, is presented again as a fresh edge.

Top module: `irq_bank_collector`

## Requirements
- R1: Input n belongs to bank n/8, bit n%8. Register access uses `busAddr` to select a bank (0, 1 or 2) and `busSel` to select a register (0 = status, 1 = enable). Reading address 3 returns 0x00, and writing address 3 changes nothing.
- R2: After reset every enable byte reads 0x00, every status byte reads 0x00 and `hostIrq` is low. A write to an enable byte stores the write data, and a read returns it. An enable bit of 1 enables its input.
- R3: A rising edge on an enabled edge-type input sets its status bit. The bit becomes readable on the third rising clock edge after the input changes.
- R4: A read strobe returns the status byte on `busRdData` after the clock edge and clears that bank's latched edge bits. The enable bytes are left unchanged.
- R5: The level-type input (input 5, bank 0 bit 5) shows in its status bit as its synchronized level ANDed with its enable bit. It is never latched, and a read does not clear it.
- R6: A rising edge that arrives while the input is disabled sets no status bit, and enabling the input afterwards does not recover it.
- R7: One cycle after any status bit ANDed with its enable bit is 1, `hostIrq` is high, provided no status read took place in that cycle.
- R8: In the cycle after any status read, `hostIrq` is low. In the cycle after that it is high again if any enabled pending bit remains.
- R9: An edge detected in the same cycle as a status read of its bank survives the read, and the next read returns it.
- R10: A write to a status byte has no effect.
- R11: Disabling an input whose bit is latched removes it from `hostIrq`. The bit stays readable in the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqIn | input | 24 | Asynchronous interrupt request lines |
| busAddr | input | 2 | Bank select |
| busSel | input | 1 | Register select: 0 status, 1 enable |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Single-cycle write strobe |
| busRdEn | input | 1 | Single-cycle read strobe |
| busRdData | output | 8 | Registered read data |
| hostIrq | output | 1 | Cascade request to the host |

## Verification
The stimulus covers several input patterns:
- A pulse while the input is disabled, which separates gated capture from capture that ignores the enable.
- Single and multi-bank edges, which expose bank and bit mapping errors.
- A held level on the level-type input, which separates pass-through from latching and from read-to-clear.
- An edge timed to land exactly on a read strobe, which checks that the new edge wins.
- Two pending sources read one at a time, which shows whether `hostIrq` drops and rises again between reads, not merely whether it is high.
- Writes to status bytes and to the unused address, which confirm that nothing changes.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int BANK_SEL_W = 2;
  localparam int MAX_BANKS  = 1 << BANK_SEL_W;

  typedef struct packed {
    logic                  maskWr;
    logic                  statRd;
    logic                  rdCapture;
    logic                  bankOk;
    logic                  selMask;
    logic [BANK_SEL_W-1:0] bank;
  } bankStrobes_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BANK_SEL_W-1:0] busAddr,
  input  logic                  busSel,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  output bankStrobes_t          strb
);
  logic bankOk;

  assign bankOk = int'(busAddr) < NUM_BANKS;

  always_comb begin
    strb           = '0;
    strb.bank      = busAddr;
    strb.bankOk    = bankOk;
    strb.selMask   = busSel;
    strb.rdCapture = busRdEn;
    strb.maskWr    = busWrEn & busSel & bankOk;
    strb.statRd    = busRdEn & ~busSel & bankOk;
  end

  // unused address must raise no register strobe
  assert_ghost_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(busAddr) >= NUM_BANKS) |-> (!strb.maskWr && !strb.statRd));
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_W      = 8,
  parameter int LEVEL_SRC   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0]   irqIn,
  input  bankStrobes_t                  strb,
  input  logic [BANK_W-1:0]             busWrData,
  output logic [BANK_W-1:0]             busRdData,
  output logic                          hostIrq
);
  localparam int NSRC = NUM_BANKS * BANK_W;
  localparam logic [NSRC-1:0] LEVEL_BIT = NSRC'(1) << LEVEL_SRC;

  logic [SYNC_STAGES-1:0][NSRC-1:0] syncQ;
  logic [NSRC-1:0] syncd, prevQ, edgeHit, statQ, clrVec;
  logic [NSRC-1:0] levelView, statView, effPend, maskFlat;
  logic [NUM_BANKS-1:0][BANK_W-1:0] maskQ;
  logic [BANK_W-1:0] rdMux;
  logic hostIrqQ, rdDataValid;
  logic [BANK_W-1:0] rdDataQ;

  // input synchronizer and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= irqIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncd;
    end
  end

  assign syncd    = syncQ[SYNC_STAGES-1];
  assign maskFlat = maskQ;
  assign edgeHit  = syncd & ~prevQ & ~LEVEL_BIT & maskFlat;

  always_comb begin
    clrVec = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      clrVec[b*BANK_W +: BANK_W] = {BANK_W{strb.statRd && (int'(strb.bank) == b)}};
  end

  // enable bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) maskQ <= '0;
    else
      for (int b = 0; b < NUM_BANKS; b++)
        if (strb.maskWr && int'(strb.bank) == b) maskQ[b] <= busWrData;
  end

  // latched edge status: a fresh edge outranks the read clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statQ <= '0;
    else        statQ <= (statQ & ~clrVec) | edgeHit;
  end

  assign levelView = syncd & LEVEL_BIT & maskFlat;
  assign statView  = statQ | levelView;
  assign effPend   = statView & maskFlat;

  always_comb begin
    rdMux = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (strb.bankOk && int'(strb.bank) == b)
        rdMux = strb.selMask ? maskQ[b] : statView[b*BANK_W +: BANK_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdDataQ     <= '0;
      rdDataValid <= 1'b0;
      hostIrqQ    <= 1'b0;
    end else begin
      rdDataValid <= strb.rdCapture;
      if (strb.rdCapture) rdDataQ <= rdMux;
      // a status read forces one low cycle so the host sees a new edge
      hostIrqQ <= (|effPend) & ~strb.statRd;
    end
  end

  assign busRdData = rdDataQ;
  assign hostIrq   = hostIrqQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bankChk
    assert_rdclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.statRd && int'(strb.bank) == b) |=>
        ((statQ[b*BANK_W +: BANK_W] & ~$past(edgeHit[b*BANK_W +: BANK_W])) == '0));
  end

  assert_masked_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((statQ & ~$past(statQ) & ~$past(maskFlat)) == '0));

  assert_rearm_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.statRd |=> !hostIrq);

  assert_cascade_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|effPend) && !strb.statRd) |=> hostIrq);

  assert_rd_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdCapture |=> rdDataValid);
endmodule

// File: rtl/irq_bank_collector.sv
module irq_bank_collector
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_W      = 8,
  parameter int LEVEL_SRC   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] irqIn,
  input  logic [BANK_SEL_W-1:0]       busAddr,
  input  logic                        busSel,
  input  logic [BANK_W-1:0]           busWrData,
  input  logic                        busWrEn,
  input  logic                        busRdEn,
  output logic [BANK_W-1:0]           busRdData,
  output logic                        hostIrq
);
  bankStrobes_t strb;

  irq_agg_ctrl #(.NUM_BANKS(NUM_BANKS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busSel(busSel),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .strb(strb)
  );

  irq_agg_dp #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
    .LEVEL_SRC(LEVEL_SRC), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .strb(strb),
    .busWrData(busWrData), .busRdData(busRdData), .hostIrq(hostIrq)
  );
endmodule

// File: tb/irq_bank_collector_tb_top.sv
module irq_bank_collector_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] irqIn = '0;
  logic [1:0] busAddr = '0;
  logic busSel = 1'b0;
  logic [7:0] busWrData = '0;
  logic busWrEn = 1'b0;
  logic busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic hostIrq;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  irq_bank_collector dut_i (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .busAddr(busAddr),
    .busSel(busSel), .busWrData(busWrData), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busRdData(busRdData), .hostIrq(hostIrq)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkIrq(input logic exp, input string tag);
    checks++;
    if (hostIrq !== exp) begin
      errors++;
      $display("FAIL %s hostIrq actual=%b expected=%b", tag, hostIrq, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic s, input logic [7:0] d);
    busAddr = a; busSel = s; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  // driver: push the expectation, then strobe the read
  task automatic busRead(input logic [1:0] a, input logic s, input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busAddr = a; busSel = s; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  // monitor: compare registered read data half a cycle after the strobe edge
  initial begin
    forever begin
      @(posedge clk);
      if (busRdEn) begin
        @(negedge clk);
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL unexpected read data actual=%h expected=none", busRdData);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (busRdData !== e) begin
            errors++;
            $display("FAIL %s busRdData actual=%h expected=%h", t, busRdData, e);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    waitCyc(3);
    rst_n = 1'b1;
    waitCyc(2);
    // R2 reset state
    checkIrq(1'b0, "R2 reset");
    for (int b = 0; b < 3; b++) begin
      busRead(2'(b), 1'b1, 8'h00, "R2 mask reset");
      busRead(2'(b), 1'b0, 8'h00, "R2 status reset");
    end
    // R2 enable write/readback
    busWrite(2'd0, 1'b1, 8'hFF);
    busWrite(2'd1, 1'b1, 8'h0F);
    busWrite(2'd2, 1'b1, 8'h80);
    busRead(2'd0, 1'b1, 8'hFF, "R2 mask0");
    busRead(2'd1, 1'b1, 8'h0F, "R2 mask1");
    busRead(2'd2, 1'b1, 8'h80, "R2 mask2");
    // R6 masked edge is lost
    irqIn[12] = 1'b1; waitCyc(3); irqIn[12] = 1'b0; waitCyc(4);
    busRead(2'd1, 1'b0, 8'h00, "R6 masked edge");
    busWrite(2'd1, 1'b1, 8'hFF);
    waitCyc(3);
    busRead(2'd1, 1'b0, 8'h00, "R6 after unmask");
    checkIrq(1'b0, "R6 no request");
    // R3 R7 R4 single edge
    irqIn[0] = 1'b1; waitCyc(5);
    checkIrq(1'b1, "R7 request up");
    busRead(2'd0, 1'b0, 8'h01, "R3 edge latched");
    checkIrq(1'b0, "R8 low after read");
    waitCyc(1);
    checkIrq(1'b0, "R4 cleared no request");
    busRead(2'd0, 1'b0, 8'h00, "R4 read cleared");
    busRead(2'd0, 1'b1, 8'hFF, "R4 mask kept");
    irqIn = '0; waitCyc(4);
    // R1 bank mapping
    irqIn[9] = 1'b1; irqIn[23] = 1'b1; waitCyc(5);
    busRead(2'd2, 1'b0, 8'h80, "R1 bank2 bit7");
    busRead(2'd1, 1'b0, 8'h02, "R1 bank1 bit1");
    busRead(2'd3, 1'b0, 8'h00, "R1 addr3 read");
    irqIn = '0; waitCyc(4);
    // R11 masking a latched bit
    irqIn[3] = 1'b1; waitCyc(5);
    busWrite(2'd0, 1'b1, 8'hF7);
    waitCyc(2);
    checkIrq(1'b0, "R11 masked hidden");
    busRead(2'd0, 1'b0, 8'h08, "R11 bit kept");
    busWrite(2'd0, 1'b1, 8'hFF);
    irqIn = '0; waitCyc(4);
    // R5 level input
    irqIn[5] = 1'b1; waitCyc(5);
    checkIrq(1'b1, "R5 level request");
    busRead(2'd0, 1'b0, 8'h20, "R5 level read");
    checkIrq(1'b0, "R8 forced low");
    waitCyc(1);
    checkIrq(1'b1, "R8 rises again");
    busRead(2'd0, 1'b0, 8'h20, "R5 not cleared");
    busWrite(2'd0, 1'b1, 8'hDF);
    busRead(2'd0, 1'b0, 8'h00, "R5 level masked");
    busWrite(2'd0, 1'b1, 8'hFF);
    irqIn = '0; waitCyc(4);
    busRead(2'd0, 1'b0, 8'h00, "R5 follows drop");
    waitCyc(1);
    checkIrq(1'b0, "R5 request gone");
    // R10 status writes ignored
    irqIn[2] = 1'b1; waitCyc(5);
    busWrite(2'd0, 1'b0, 8'h00);
    busRead(2'd0, 1'b0, 8'h04, "R10 status write ignored");
    busWrite(2'd1, 1'b0, 8'hFF);
    busRead(2'd1, 1'b0, 8'h00, "R10 status write no set");
    busWrite(2'd3, 1'b1, 8'h00);
    busRead(2'd0, 1'b1, 8'hFF, "R1 addr3 write ignored");
    irqIn = '0; waitCyc(4);
    // R9 edge collides with read
    irqIn[6] = 1'b1; waitCyc(2);
    busRead(2'd0, 1'b0, 8'h00, "R9 read at edge");
    busRead(2'd0, 1'b0, 8'h40, "R9 edge survived");
    irqIn = '0; waitCyc(4);
    // R8 re-arm with a second pending bank
    irqIn[1] = 1'b1; irqIn[8] = 1'b1; waitCyc(5);
    busRead(2'd0, 1'b0, 8'h02, "R8 first bank");
    checkIrq(1'b0, "R8 low between");
    waitCyc(1);
    checkIrq(1'b1, "R8 second pending");
    busRead(2'd1, 1'b0, 8'h01, "R8 second bank");
    waitCyc(1);
    checkIrq(1'b0, "R7 all serviced");
    irqIn = '0;
    waitCyc(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule